// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches every data memory access made by a processor core and flags the accesses that touch an address software has marked for debugging. Two 32-bit address registers and one control register sit behind a small register-access port. A second port carries each access as it happens: an address, a valid strobe and a flag that tells a load from a store. One cycle after a matching access, a two-bit hit output reports which watch register fired.

The first address register is always a watch address. The second register has two modes, chosen by a control bit. In watch mode it is an independent second watch address with its own enable. In mask mode it is a bit mask for the first register: a 1 in the mask removes that address bit from the first comparison, so one register pair can cover an aligned range or a scattered set of addresses. Each watch address has a two-bit enable field that turns it off or limits it to stores, loads, or any access. Exception entry and the debug handler that reacts to the hit are outside the block.

Top module: `dwatch_unit`

## Requirements
- R1: After a synchronous reset the control register reads 0x00000000 and both hit bits are 0, so neither watch address can fire until the control register is written.
- R2: The control register (select 2) keeps only bit 8 (second register mode: 0 watch address, 1 mask), bits 3:2 (second enable) and bits 1:0 (first enable). All other bits read as zero and ignore writes, so writing 0xFFFFFFFF reads back 0x0000010F.
- R3: Both address registers (select 0 for the first, select 1 for the second) store and read back all 32 bits. Register reads are combinational from the current select.
- R4: The first enable field uses 00 off, 01 stores only, 10 any access, 11 loads only. An access is a load when `acc_load` is 1 and a store when it is 0. The first watch fires on an exact address match when the second register is in watch mode.
- R5: In watch mode the second register fires on an exact match with its own address under the same four-way enable encoding in control bits 3:2.
- R6: In mask mode the first watch fires when (address XOR first register) AND NOT (second register) is zero. The second enable field has no effect and `hit[1]` never rises.
- R7: No hit is reported for a cycle in which `acc_valid` is 0, whatever the address.
- R8: `hit` is registered: a matching access in cycle n sets the hit bit in cycle n+1 only. `hit[0]` belongs to the first register and `hit[1]` to the second. Both bits are set together when one access matches both.
- R9: A register write takes effect from the next cycle on. An access in the same cycle as a write is compared against the old register contents.
- R10: Select 3 addresses no register: it reads as zero and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 first address, 1 second address, 2 control, 3 none |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Data access present this cycle |
| acc_load | input | 1 | 1 for a load, 0 for a store |
| acc_addr | input | 32 | Virtual address of the access |
| hit | output | 2 | Registered hit flags, bit 0 first register, bit 1 second register |

## Verification
The bench goes after the mask arithmetic, loading the first register and a mask and then sweeping addresses that differ only inside the mask, only outside it, or in both places. A design that inverted the mask sense or let the mask gate the wrong operand would miss the in-mask hits or report the out-of-mask ones. It also pairs control writes with accesses in the same cycle: a design that compared against the new settings would report a hit one access early or late. It checks the four enable codes against loads and stores, checks that the second enable is dead in mask mode, and checks that reserved control bits and the unused select stay at zero. Randomly drawn writes and near-miss addresses follow, scored against a bench model.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

  typedef enum logic [1:0] {
    EN_OFF   = 2'b00,
    EN_STORE = 2'b01,
    EN_ANY   = 2'b10,
    EN_LOAD  = 2'b11
  } bp_en_e;

  typedef enum logic [1:0] {
    SEL_ADDR0 = 2'd0,
    SEL_ADDR1 = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  localparam int unsigned MODE_BIT = 8;

  function automatic logic kind_ok(bp_en_e en, logic is_load);
    case (en)
      EN_STORE: kind_ok = !is_load;
      EN_ANY:   kind_ok = 1'b1;
      EN_LOAD:  kind_ok = is_load;
      default:  kind_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs
  import dwatch_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic [AW-1:0] addr0,
  output logic [AW-1:0] addr1,
  output logic          mask_mode,
  output bp_en_e        en0,
  output bp_en_e        en1
);

  logic [AW-1:0] ctl_word;

  // address registers carry no reset
  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel == SEL_ADDR0) addr0 <= cfg_wdata;
    if (cfg_we && cfg_sel == SEL_ADDR1) addr1 <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_mode <= 1'b0;
      en0       <= EN_OFF;
      en1       <= EN_OFF;
    end else if (cfg_we && cfg_sel == SEL_CTRL) begin
      mask_mode <= cfg_wdata[MODE_BIT];
      en1       <= bp_en_e'(cfg_wdata[3:2]);
      en0       <= bp_en_e'(cfg_wdata[1:0]);
    end
  end

  always_comb begin
    ctl_word           = '0;
    ctl_word[MODE_BIT] = mask_mode;
    ctl_word[3:2]      = en1;
    ctl_word[1:0]      = en0;
  end

  always_comb begin
    case (cfg_sel)
      SEL_ADDR0: cfg_rdata = addr0;
      SEL_ADDR1: cfg_rdata = addr1;
      SEL_CTRL:  cfg_rdata = ctl_word;
      default:   cfg_rdata = '0;
    endcase
  end

  // R1: control comes out of reset fully disabled
  a_r1_reset_ctrl: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en0 == EN_OFF && en1 == EN_OFF && !mask_mode));

  // R9: a control write lands exactly one edge later
  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_CTRL) |=> (en0 == bp_en_e'($past(cfg_wdata[1:0]))));

endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
  import dwatch_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_load,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] bp_addr,
  input  logic [AW-1:0] bp_mask,
  input  bp_en_e        bp_en,
  input  logic          bp_live,
  output logic          hit_q
);

  logic addr_eq;
  logic hit_d;

  assign addr_eq = ((acc_addr ^ bp_addr) & ~bp_mask) == '0;
  assign hit_d   = acc_valid && bp_live && kind_ok(bp_en, acc_load) && addr_eq;

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_d;
  end

  // R7: a hit always traces back to a valid access
  a_r7_valid_only: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(acc_valid));

  // R4: store-only enable never fires on a load
  a_r4_store_only: assert property (@(posedge clk) disable iff (rst)
    (hit_q && $past(bp_en) == EN_STORE) |-> !$past(acc_load));

  // R4: load-only enable never fires on a store
  a_r4_load_only: assert property (@(posedge clk) disable iff (rst)
    (hit_q && $past(bp_en) == EN_LOAD) |-> $past(acc_load));

  // R4: a disabled comparator stays quiet
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(bp_en) == EN_OFF) |-> !hit_q);

endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          acc_valid,
  input  logic          acc_load,
  input  logic [AW-1:0] acc_addr,
  output logic [1:0]    hit
);

  localparam int unsigned NBP = 2;

  logic [AW-1:0] addr0, addr1;
  logic          mask_mode;
  bp_en_e        en0, en1;

  logic [AW-1:0] cmp_addr [NBP];
  logic [AW-1:0] cmp_mask [NBP];
  bp_en_e        cmp_en   [NBP];
  logic          cmp_live [NBP];

  dwatch_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .addr0(addr0), .addr1(addr1), .mask_mode(mask_mode),
    .en0(en0), .en1(en1)
  );

  always_comb begin
    cmp_addr[0] = addr0;
    cmp_mask[0] = mask_mode ? addr1 : '0;
    cmp_en[0]   = en0;
    cmp_live[0] = 1'b1;
    cmp_addr[1] = addr1;
    cmp_mask[1] = '0;
    cmp_en[1]   = en1;
    cmp_live[1] = !mask_mode;
  end

  for (genvar g = 0; g < NBP; g++) begin : g_bp
    dwatch_cmp #(.AW(AW)) cmp_i (
      .clk(clk), .rst(rst),
      .acc_valid(acc_valid), .acc_load(acc_load), .acc_addr(acc_addr),
      .bp_addr(cmp_addr[g]), .bp_mask(cmp_mask[g]),
      .bp_en(cmp_en[g]), .bp_live(cmp_live[g]),
      .hit_q(hit[g])
    );
  end

  // R6: the second register never fires while it acts as a mask
  a_r6_mask_silent: assert property (@(posedge clk) disable iff (rst)
    hit[1] |-> !$past(mask_mode));

  // R7: an idle access port yields no hit next cycle
  a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (hit == 2'b00));

  // R5: second-register hit implies an exact address match
  a_r5_exact: assert property (@(posedge clk) disable iff (rst)
    hit[1] |-> ($past(acc_addr) == $past(addr1)));

endmodule

// File: tb/dwatch_unit_tb.sv
module dwatch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_valid;
  logic        acc_load;
  logic [31:0] acc_addr;
  logic [1:0]  hit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [31:0] sh_a0, sh_a1, sh_ctl;

  always #2 clk = ~clk;   // 250 MHz

  dwatch_unit #(.AW(32)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_load(acc_load), .acc_addr(acc_addr),
    .hit(hit)
  );

  function automatic logic kind_allows(logic [1:0] e, logic ld);
    case (e)
      2'b01:   return !ld;
      2'b10:   return 1'b1;
      2'b11:   return ld;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] model_hit(logic [31:0] ctl, logic [31:0] a0,
      logic [31:0] a1, logic v, logic ld, logic [31:0] ad);
    logic [31:0] m;
    logic h0, h1;
    m  = ctl[8] ? a1 : 32'd0;
    h0 = v && kind_allows(ctl[1:0], ld) && (((ad ^ a0) & ~m) == 32'd0);
    h1 = v && !ctl[8] && kind_allows(ctl[3:2], ld) && (ad == a1);
    return {h1, h0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: optional write plus optional access; hit checked after the edge
  task automatic step(string tag, logic we, logic [1:0] sel, logic [31:0] wd,
                      logic v, logic ld, logic [31:0] ad);
    logic [1:0] exp;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    acc_valid = v; acc_load = ld; acc_addr = ad;
    exp = model_hit(sh_ctl, sh_a0, sh_a1, v, ld, ad);
    @(posedge clk);
    #1;
    if (we) begin
      case (sel)
        2'd0: sh_a0 = wd;
        2'd1: sh_a1 = wd;
        2'd2: sh_ctl = wd & 32'h0000_010F;
        default: ;
      endcase
    end
    check(tag, {30'd0, hit}, {30'd0, exp});
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] wd);
    step("write", 1'b1, sel, wd, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic rd(string tag, logic [1:0] sel, logic [31:0] exp);
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = sel; acc_valid = 1'b0;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_load = 1'b0; acc_addr = '0;
    sh_a0 = '0; sh_a1 = '0; sh_ctl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1
    rd("R1 ctrl after reset", 2'd2, 32'd0);
    check("R1 hit after reset", {30'd0, hit}, 32'd0);

    // R3
    wr(2'd0, 32'hA5A5_1234); wr(2'd1, 32'h5A5A_EDCB);
    rd("R3 addr0 readback", 2'd0, 32'hA5A5_1234);
    rd("R3 addr1 readback", 2'd1, 32'h5A5A_EDCB);

    // R2 and R10
    wr(2'd2, 32'hFFFF_FFFF);
    rd("R2 ctrl reserved", 2'd2, 32'h0000_010F);
    wr(2'd3, 32'hDEAD_BEEF);
    rd("R10 unused select", 2'd3, 32'd0);
    rd("R10 addr0 untouched", 2'd0, 32'hA5A5_1234);
    rd("R10 addr1 untouched", 2'd1, 32'h5A5A_EDCB);
    rd("R10 ctrl untouched", 2'd2, 32'h0000_010F);

    // R4: each enable code on the first register
    wr(2'd2, 32'h0); wr(2'd0, 32'h0000_1000); wr(2'd1, 32'h0000_2000);
    for (int e = 0; e < 4; e++) begin
      wr(2'd2, e);
      step("R4 first load", 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h0000_1000);
      step("R4 first store", 1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 32'h0000_1000);
      step("R4 first near miss", 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h0000_1004);
    end

    // R5: each enable code on the second register
    for (int e = 0; e < 4; e++) begin
      wr(2'd2, e << 2);
      step("R5 second load", 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h0000_2000);
      step("R5 second store", 1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 32'h0000_2000);
    end

    // R8: both fire on one access, then clear
    wr(2'd1, 32'h0000_1000); wr(2'd2, 32'h0000_000A);
    step("R8 both bits", 1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 32'h0000_1000);
    check("R8 both bits value", {30'd0, hit}, 32'd3);
    step("R8 one cycle only", 1'b0, 2'd0, 32'd0, 1'b0, 1'b0, 32'h0000_1000);

    // R7
    step("R7 no valid", 1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 32'h0000_1000);

    // R6: mask mode, second enable set to any yet silent
    wr(2'd0, 32'h8000_0100); wr(2'd1, 32'h0000_00FF); wr(2'd2, 32'h0000_010A);
    step("R6 in-mask hit", 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h8000_01C3);
    step("R6 mask addr silent", 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h0000_00FF);
    step("R6 out-of-mask miss", 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h8000_0200);
    step("R6 both places miss", 1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 32'h0000_0133);

    // R9: access alongside a write uses old contents
    step("R9 disable same cycle", 1'b1, 2'd2, 32'h0, 1'b1, 1'b1, 32'h8000_0100);
    step("R9 disabled after", 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h8000_0100);
    step("R9 enable same cycle", 1'b1, 2'd2, 32'h2, 1'b1, 1'b1, 32'h8000_0100);
    step("R9 addr change same", 1'b1, 2'd0, 32'h0000_4000, 1'b1, 1'b0, 32'h8000_0100);
    step("R9 new addr live", 1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 32'h0000_4000);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      logic we;
      logic [1:0] sel;
      logic [31:0] wd, ad;
      r  = $urandom_range(0, 99);
      we = 1'b0; sel = 2'd0; wd = $urandom;
      if (r < 8)       begin we = 1'b1; sel = 2'd2; end
      else if (r < 12) begin we = 1'b1; sel = 2'd0; end
      else if (r < 16) begin we = 1'b1; sel = 2'd1; wd = wd & ($urandom | 32'hFFFF_0000); end
      else if (r < 18) begin we = 1'b1; sel = 2'd3; end
      case ($urandom_range(0, 3))
        0: ad = sh_a0;
        1: ad = sh_a1;
        2: ad = sh_a0 ^ ($urandom & sh_a1);
        default: ad = sh_a0 ^ (32'd1 << $urandom_range(0, 31));
      endcase
      step("R4 R5 R6 R9 random", we, sel, wd, $urandom_range(0, 3) != 0,
           1'($urandom_range(0, 1)), ad);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule